// File: doc/BRIEF.md
# Charging Port Mode Controller

This block picks the operating mode of a USB charging port from three control inputs and a limit-select input. The modes are a held-discharge state, an automatic dedicated-charging state, a standard downstream port, two forced dedicated-charging signatures (shorted data lines and divider 1), and a charging downstream port. From the mode it drives the power-switch enable, the output-discharge enable, the data-line pass-switch enable, the high/low current-limit select and a one-hot set of mode flags. The analog signature circuits read these flags.

The inputs are asynchronous, so each one passes through two flip-flops. A new control code takes effect only after it has been sampled at the same value on two consecutive millisecond ticks. When the accepted mode changes, the power switch opens and the output is discharged for a fixed number of ticks before power returns. There is one exception: a move between the standard port coded 1110 and the charging downstream port coded 1111 keeps power on. A further change during a running discharge restarts the interval and aims at the newest code.

Top module: `chg_mode_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the accepted mode is the held-discharge mode. In that state pwr_on=0, dis_on=1 and data_on=0, and the discharge timer is loaded with DIS_TICKS ticks.
- R2: Codes are written {ctl[2],ctl[1],ctl[0],lim_sel}. 000x decodes to held discharge (flag bit 0). 001x and 011x decode to automatic dedicated charging (bit 1). 010x, 1100, 1101 and 1110 decode to standard port (bit 2). 100x decodes to forced shorted (bit 3). 101x decodes to forced divider 1 (bit 4). 1111 decodes to charging downstream port (bit 5). Exactly one flag is set at all times.
- R3: ilim_hi is 1 in automatic dedicated charging and in charging downstream port. In every other mode it equals the lim_sel bit of the accepted code.
- R4: An accepted code whose mode differs from the previous one opens the power switch and sets dis_on. The output stays in discharge for DIS_TICKS ticks, counting from the accepting tick. On the tick after that, power returns unless the new mode is held discharge.
- R5: No discharge interval is inserted for a change between 1110 and 1111, or for a change that keeps the same mode (a lim_sel change within one mode). The outputs take the new code on the accepting edge.
- R6: data_on is 1 only when the synchronized enable is high and the mode is standard port or charging downstream port. It is 0 in every dedicated-charging mode and in held discharge.
- R7: A low enable, after two clocks of synchronization, forces pwr_on=0, dis_on=1 and data_on=0.
- R8: A code is accepted only on a tick, and only if its synchronized value was the same on that tick and on the tick before. A code that lasts for a single tick is ignored.
- R9: A mode change accepted during a running discharge reloads the full DIS_TICKS interval and targets the newest code.
- R10: In the held-discharge mode, dis_on stays 1 and pwr_on stays 0 after the timer expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| ctl | input | 3 | Mode-control inputs, ctl[2] first |
| lim_sel | input | 1 | Current-limit select input |
| en | input | 1 | Port enable |
| mode_flags | output | 6 | One-hot mode flags (bit order in R2) |
| pwr_on | output | 1 | Power-switch enable |
| dis_on | output | 1 | Output-discharge enable |
| data_on | output | 1 | Data-line pass-switch enable |
| ilim_hi | output | 1 | High current-limit select |

## Verification
The bench builds the block with DIS_TICKS=5. With that value, every ordered pair of the 16 control codes can be swept, and each pair waits out its full discharge interval. This covers all mode transitions, the sibling exception and the same-mode lim_sel changes. For each pair, the bench checks the outputs on the accepting edge, one tick before the interval ends and on the tick it ends. The short interval also makes the restart-during-discharge, single-tick glitch, enable and mid-run reset cases quick to reach.

// File: rtl/chg_mode_pkg.sv
package chg_mode_pkg;

  typedef enum logic [2:0] {
    MD_HOLD  = 3'd0,
    MD_AUTO  = 3'd1,
    MD_STD   = 3'd2,
    MD_SHORT = 3'd3,
    MD_DIV1  = 3'd4,
    MD_CHG   = 3'd5
  } mode_e;

  // code = {ctl[2], ctl[1], ctl[0], lim_sel}
  function automatic mode_e decode_mode(input logic [3:0] code);
    mode_e m;
    case (code[3:1])
      3'b000:  m = MD_HOLD;
      3'b001:  m = MD_AUTO;
      3'b011:  m = MD_AUTO;
      3'b010:  m = MD_STD;
      3'b100:  m = MD_SHORT;
      3'b101:  m = MD_DIV1;
      3'b110:  m = MD_STD;
      default: m = code[0] ? MD_CHG : MD_STD;
    endcase
    return m;
  endfunction

  function automatic logic is_sibling(input logic [3:0] a, input logic [3:0] b);
    return ((a == 4'b1110) && (b == 4'b1111)) || ((a == 4'b1111) && (b == 4'b1110));
  endfunction

  function automatic logic needs_discharge(input logic [3:0] from_c, input logic [3:0] to_c);
    return (decode_mode(from_c) != decode_mode(to_c)) && !is_sibling(from_c, to_c);
  endfunction

  function automatic logic limit_high(input logic [3:0] code);
    mode_e m;
    m = decode_mode(code);
    return (m == MD_AUTO) || (m == MD_CHG) || code[0];
  endfunction

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/chg_stab_filter.sv
module chg_stab_filter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] code_in,
  input  logic [W-1:0] cur_code,
  output logic         accept
);
  logic [W-1:0] prev_code;

  assign accept = tick && (code_in == prev_code) && (code_in != cur_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_code <= '0;
    else if (tick) prev_code <= code_in;
  end

  // R8: a code accepted now was already sampled on the previous tick
  assert_prev_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (prev_code == $past(code_in)));
endmodule

// File: rtl/chg_dis_timer.sv
module chg_dis_timer #(
  parameter int TICKS = 310
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic active
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt;
  logic          last_tick;

  assign last_tick = active && tick && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b1;
      cnt    <= CW'(TICKS);
    end else if (restart) begin
      active <= 1'b1;
      cnt    <= CW'(TICKS);
    end else if (active && tick) begin
      if (last_tick) active <= 1'b0;
      else           cnt    <= cnt - CW'(1);
    end
  end

  assert_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_tick && !restart) |=> !active);
  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !restart) |=> !active);
  assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (active && cnt == CW'(TICKS)));
endmodule

// File: rtl/chg_mode_ctrl.sv
module chg_mode_ctrl #(
  parameter int DIS_TICKS = 310
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic [2:0] ctl,
  input  logic       lim_sel,
  input  logic       en,
  output logic [5:0] mode_flags,
  output logic       pwr_on,
  output logic       dis_on,
  output logic       data_on,
  output logic       ilim_hi
);
  import chg_mode_pkg::*;

  localparam int CODE_W = 4;

  logic [CODE_W:0]   sync_q;
  logic [CODE_W-1:0] code_s;
  logic              en_s;
  logic [CODE_W-1:0] acc_code;
  logic              accept_evt;
  logic              restart_evt;
  logic              sibling_evt;
  logic              dis_active;
  mode_e             cur_mode;

  chg_sync #(.W(CODE_W + 1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ctl, lim_sel, en}),
    .q    (sync_q)
  );

  assign code_s = sync_q[CODE_W:1];
  assign en_s   = sync_q[0];

  chg_stab_filter #(.W(CODE_W)) u_stab (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ms_tick),
    .code_in (code_s),
    .cur_code(acc_code),
    .accept  (accept_evt)
  );

  assign restart_evt = accept_evt && needs_discharge(acc_code, code_s);
  assign sibling_evt = accept_evt && is_sibling(acc_code, code_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_code <= '0;
    else if (accept_evt) acc_code <= code_s;
  end

  chg_dis_timer #(.TICKS(DIS_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (ms_tick),
    .restart(restart_evt),
    .active (dis_active)
  );

  assign cur_mode = decode_mode(acc_code);

  always_comb begin
    mode_flags = '0;
    mode_flags[cur_mode] = 1'b1;
  end

  assign pwr_on  = en_s && !dis_active && (cur_mode != MD_HOLD);
  assign dis_on  = !en_s || dis_active || (cur_mode == MD_HOLD);
  assign data_on = en_s && ((cur_mode == MD_STD) || (cur_mode == MD_CHG));
  assign ilim_hi = limit_high(acc_code);

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_flags) == 1);
  assert_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_flags[1] || mode_flags[5]) |-> ilim_hi);
  assert_restart_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (!pwr_on && dis_on));
  assert_sibling_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sibling_evt && pwr_on) |=> (pwr_on || !en_s));
  assert_data_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_on |-> !(mode_flags[0] || mode_flags[1] || mode_flags[3] || mode_flags[4]));
  assert_en_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |-> (!pwr_on && !data_on && dis_on));
  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> $stable(acc_code));
  assert_hold_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flags[0] |-> (dis_on && !pwr_on));
endmodule

// File: tb/sim_chg_mode_ctrl.sv
module sim_chg_mode_ctrl;
  localparam int DT = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic [2:0] ctl = 3'b000;
  logic       lim_sel = 1'b0;
  logic       en = 1'b1;
  logic [5:0] mode_flags;
  logic       pwr_on, dis_on, data_on, ilim_hi;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chg_mode_ctrl #(.DIS_TICKS(DT)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ctl(ctl), .lim_sel(lim_sel),
    .en(en), .mode_flags(mode_flags), .pwr_on(pwr_on), .dis_on(dis_on),
    .data_on(data_on), .ilim_hi(ilim_hi)
  );

  function automatic int exp_mode(input logic [3:0] c);
    if (c[3:1] == 3'b000) return 0;
    if (!c[3] && c[1])    return 1;
    if (!c[3])            return 2;
    if (!c[2])            return c[1] ? 4 : 3;
    if (c[1] && c[0])     return 5;
    return 2;
  endfunction

  function automatic bit exp_dis(input logic [3:0] a, input logic [3:0] b);
    bit sib;
    sib = ({a, b} == 8'hEF) || ({a, b} == 8'hFE);
    return (exp_mode(a) != exp_mode(b)) && !sib;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic apply(input logic [3:0] c);
    @(negedge clk) {ctl, lim_sel} = c;
    clks(3);
    ticks(2);
  endtask

  task automatic chk_all(input string req, input logic [3:0] c, input bit dis_exp);
    int m;
    bit p;
    m = exp_mode(c);
    p = en && !dis_exp && (m != 0);
    chk({req, " flags"}, mode_flags, 1 << m);
    chk({req, " ilim"}, ilim_hi, (m == 1 || m == 5) ? 1 : int'(c[0]));
    chk({req, " data"}, data_on, (en && (m == 2 || m == 5)) ? 1 : 0);
    chk({req, " pwr"}, pwr_on, p);
    chk({req, " dis"}, dis_on, !p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    clks(4);
    chk_all("R1 in reset", 4'b0000, 1'b1);
    rst_n = 1'b1;
    clks(3);
    chk_all("R1 after reset", 4'b0000, 1'b1);
    ticks(DT + 1);
    chk_all("R10 hold after timer", 4'b0000, 1'b0);

    // R2 R3 R4 R5 R6 sweep of all ordered code pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        bit d;
        apply(4'(a));
        ticks(DT);
        apply(4'(b));
        d = exp_dis(4'(a), 4'(b));
        chk_all(d ? "R4 accept" : "R5 no-dis", 4'(b), d);
        if (d) begin
          ticks(DT - 1);
          chk_all("R4 before end", 4'(b), 1'b1);
          ticks(1);
          chk_all("R4 released", 4'(b), 1'b0);
        end
      end
    end

    // R8: code not accepted before two matching ticks; single-tick glitch ignored
    apply(4'b1111); ticks(DT);
    @(negedge clk) {ctl, lim_sel} = 4'b1000;
    clks(3);
    ticks(1);
    chk_all("R8 one tick", 4'b1111, 1'b0);
    @(negedge clk) {ctl, lim_sel} = 4'b1111;
    clks(3);
    ticks(3);
    chk_all("R8 glitch ignored", 4'b1111, 1'b0);
    @(negedge clk) {ctl, lim_sel} = 4'b0100;
    clks(5);
    chk_all("R8 no tick no change", 4'b1111, 1'b0);
    ticks(2);
    chk_all("R8 accepted", 4'b0100, 1'b1);
    ticks(DT);

    // R9: change mid-discharge reloads full interval
    apply(4'b1000);
    ticks(2);
    apply(4'b1010);
    chk_all("R9 new target", 4'b1010, 1'b1);
    ticks(DT - 1);
    chk_all("R9 still discharging", 4'b1010, 1'b1);
    ticks(1);
    chk_all("R9 released", 4'b1010, 1'b0);

    // R7: enable low
    apply(4'b1111); ticks(DT);
    @(negedge clk) en = 1'b0;
    clks(3);
    chk_all("R7 en low", 4'b1111, 1'b0);
    @(negedge clk) en = 1'b1;
    clks(3);
    chk_all("R7 en high", 4'b1111, 1'b0);

    // R1: reset from an active mode
    @(negedge clk) rst_n = 1'b0;
    clks(2);
    chk_all("R1 mid reset", 4'b0000, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    clks(3);
    ticks(2);
    chk_all("R1 reaccept", 4'b1111, 1'b1);
    ticks(DT);
    chk_all("R1 power back", 4'b1111, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule